// File: doc/BRIEF.md
# UART Channel Mode Router

This block sits between a UART channel's transmit and receive shift engines, its two serial pins and its CPU-facing status logic. It picks one of four operating modes and, from that choice, decides where the TxD pin gets its data, what serial stream the receiver sees, and which bit-rate tick each engine runs from. It also decides which status, data-delivery and error signals reach the CPU side. The shift engines and baud generators are outside the block. The block receives their ticks as one-cycle clock-enable pulses on a single system clock.

For retransmission, the block has a one-stage re-clocking register. On every receive tick it captures the RxD pin, so TxD repeats the received line one sample period later. Parity bits, stop bits and break conditions go out exactly as they arrived. Mode selection is combinational, so a new mode takes effect in the cycle it is applied, even partway through a character.

Top module: `crm_mode_router`

## Requirements
- R1: Mode encoding on `mode_sel` is 0 = normal, 1 = automatic echo, 2 = local loopback, 3 = remote loopback. In normal mode, `txd` follows `tx_serial` and `rx_serial` follows `rxd`. Each engine keeps its own tick, and every status, data and error input passes through unchanged, with both receive checks enabled.
- R2: While `rx_en` is high, the re-clocking register captures `rxd` in every cycle that has `rx_tick`. In echo and remote loopback modes, `txd` equals that register, so it changes one clock after the sampling tick. In those two modes `tx_tick_sel` equals `rx_tick`.
- R3: In echo mode, `tx_ready`, `tx_empty` and `tx_load` are all held low. Receive push, error flags and both receive checks pass through as in normal mode.
- R4: In local loopback mode, `txd` is held at 1 and `rx_serial` equals `tx_serial`, so `rxd` has no effect. `rx_tick_sel` equals `tx_tick`.
- R5: In remote loopback mode, `rx_push`, `rx_perr`, `rx_ferr`, `rx_brk`, `rx_chk_parity` and `rx_chk_frame` are all 0, whatever their inputs are.
- R6: A low level held on `rxd` across many receive ticks (a break) is repeated on `txd` for as long as it lasts. `txd` returns high one tick after `rxd` does.
- R7: A change of `mode_sel` changes the routing in the same cycle, with no clock of delay. This holds even while a character is being retransmitted.
- R8: `tx_run` equals `tx_en` in normal and local loopback modes and is 0 in echo and remote loopback. `rx_run` equals `rx_en` except in local loopback, where it equals `tx_en` and `rx_en` is ignored. When `rx_en` is low, the re-clocking register returns to 1 on the next clock.
- R9: Synchronous reset (`rst` high at a clock edge) sets the re-clocking register to the idle level 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Operating mode (see R1) |
| tx_en | input | 1 | Transmitter enable from control logic |
| rx_en | input | 1 | Receiver enable from control logic |
| tx_tick | input | 1 | Transmit bit-rate tick |
| rx_tick | input | 1 | Receive bit-rate tick |
| tx_serial | input | 1 | Serial output of the transmit engine |
| rxd | input | 1 | Receive data pin |
| txd | output | 1 | Transmit data pin |
| rx_serial | output | 1 | Serial input to the receive engine |
| tx_tick_sel | output | 1 | Tick that drives the transmit engine |
| rx_tick_sel | output | 1 | Tick that drives the receive engine |
| tx_run | output | 1 | Effective transmit engine enable |
| rx_run | output | 1 | Effective receive engine enable |
| cpu_tx_load | input | 1 | CPU request to load a transmit character |
| tx_load | output | 1 | Gated load to the transmit engine |
| tx_ready_in | input | 1 | Transmit holding register ready, from engine |
| tx_empty_in | input | 1 | Transmitter fully empty, from engine |
| tx_ready | output | 1 | CPU-visible transmit ready |
| tx_empty | output | 1 | CPU-visible transmitter empty |
| rx_push_in | input | 1 | Received character ready to be stored |
| rx_perr_in | input | 1 | Parity error of that character |
| rx_ferr_in | input | 1 | Framing error of that character |
| rx_brk_in | input | 1 | Break flag of that character |
| rx_push | output | 1 | Gated character store toward the CPU |
| rx_perr | output | 1 | Gated parity error |
| rx_ferr | output | 1 | Gated framing error |
| rx_brk | output | 1 | Gated break flag |
| rx_chk_parity | output | 1 | Tells the receive engine to check parity |
| rx_chk_frame | output | 1 | Tells the receive engine to check framing |

## Verification
The assertions assume that each tick input is a single-cycle pulse aligned to `clk`, and that `mode_sel`, the enables and the pin inputs change only between clock edges. The bench drives every input on the falling edge and samples half a period later, which keeps it inside that assumption. The echo-register properties look back one cycle only. The bench releases reset before any property that depends on the register's history can become active.

// File: rtl/crm_pkg.sv
package crm_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_ECHO   = 2'd1,
        MODE_LOCAL  = 2'd2,
        MODE_REMOTE = 2'd3
    } chan_mode_e;

    typedef struct packed {
        logic normal;
        logic echo;
        logic local_lb;
        logic remote;
    } route_sel_t;

    typedef struct packed {
        logic push;
        logic perr;
        logic ferr;
        logic brk;
    } rx_stat_t;

    localparam logic LINE_IDLE = 1'b1;

    function automatic route_sel_t decode_mode(input logic [1:0] m);
        route_sel_t s;
        s.normal   = (m == MODE_NORMAL);
        s.echo     = (m == MODE_ECHO);
        s.local_lb = (m == MODE_LOCAL);
        s.remote   = (m == MODE_REMOTE);
        return s;
    endfunction

    function automatic logic retransmits(input route_sel_t s);
        return s.echo | s.remote;
    endfunction

endpackage

// File: rtl/crm_mode_decode.sv
module crm_mode_decode
    import crm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    output route_sel_t sel
);
    always_comb sel = decode_mode(mode_sel);

    // R1
    one_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot({sel.normal, sel.echo, sel.local_lb, sel.remote}));
endmodule

// File: rtl/crm_echo_reclock.sv
module crm_echo_reclock
    import crm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rx_en,
    input  logic rx_tick,
    input  logic rxd,
    output logic echo_bit
);
    always_ff @(posedge clk) begin
        if (rst)
            echo_bit <= LINE_IDLE;
        else if (!rx_en)
            echo_bit <= LINE_IDLE;
        else if (rx_tick)
            echo_bit <= rxd;
    end

    // R2
    echo_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_en && rx_tick) |=> (echo_bit == $past(rxd)));

    // R2
    echo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_en && !rx_tick) |=> $stable(echo_bit));

    // R8
    echo_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (echo_bit == LINE_IDLE));
endmodule

// File: rtl/crm_status_gate.sv
module crm_status_gate
    import crm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  route_sel_t sel,
    input  logic       cpu_tx_load,
    input  logic       tx_ready_in,
    input  logic       tx_empty_in,
    input  rx_stat_t   rx_in,
    output logic       tx_load,
    output logic       tx_ready,
    output logic       tx_empty,
    output rx_stat_t   rx_out,
    output logic       chk_parity,
    output logic       chk_frame
);
    always_comb begin
        tx_load    = cpu_tx_load & ~sel.echo;
        tx_ready   = tx_ready_in & ~sel.echo;
        tx_empty   = tx_empty_in & ~sel.echo;
        rx_out     = sel.remote ? '0 : rx_in;
        chk_parity = ~sel.remote;
        chk_frame  = ~sel.remote;
    end

    // R3
    echo_tx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sel.echo |-> !(tx_ready || tx_empty || tx_load));

    // R5
    remote_rx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sel.remote |-> ($countones(rx_out) == 0 && !chk_parity && !chk_frame));
endmodule

// File: rtl/crm_mode_router.sv
module crm_mode_router
    import crm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic       tx_tick,
    input  logic       rx_tick,
    input  logic       tx_serial,
    input  logic       rxd,
    output logic       txd,
    output logic       rx_serial,
    output logic       tx_tick_sel,
    output logic       rx_tick_sel,
    output logic       tx_run,
    output logic       rx_run,
    input  logic       cpu_tx_load,
    output logic       tx_load,
    input  logic       tx_ready_in,
    input  logic       tx_empty_in,
    output logic       tx_ready,
    output logic       tx_empty,
    input  logic       rx_push_in,
    input  logic       rx_perr_in,
    input  logic       rx_ferr_in,
    input  logic       rx_brk_in,
    output logic       rx_push,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_brk,
    output logic       rx_chk_parity,
    output logic       rx_chk_frame
);
    route_sel_t sel;
    logic       echo_bit;
    logic       rexmit;
    rx_stat_t   rx_in_s;
    rx_stat_t   rx_out_s;

    crm_mode_decode u_dec (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .sel(sel)
    );

    crm_echo_reclock u_echo (
        .clk(clk), .rst(rst), .rx_en(rx_en), .rx_tick(rx_tick),
        .rxd(rxd), .echo_bit(echo_bit)
    );

    assign rx_in_s = '{push: rx_push_in, perr: rx_perr_in,
                       ferr: rx_ferr_in, brk: rx_brk_in};

    crm_status_gate u_gate (
        .clk(clk), .rst(rst), .sel(sel),
        .cpu_tx_load(cpu_tx_load), .tx_ready_in(tx_ready_in),
        .tx_empty_in(tx_empty_in), .rx_in(rx_in_s),
        .tx_load(tx_load), .tx_ready(tx_ready), .tx_empty(tx_empty),
        .rx_out(rx_out_s), .chk_parity(rx_chk_parity), .chk_frame(rx_chk_frame)
    );

    assign rexmit = retransmits(sel);

    always_comb begin
        if (sel.local_lb)  txd = LINE_IDLE;
        else if (rexmit)   txd = echo_bit;
        else               txd = tx_serial;
        rx_serial   = sel.local_lb ? tx_serial : rxd;
        tx_tick_sel = rexmit ? rx_tick : tx_tick;
        rx_tick_sel = sel.local_lb ? tx_tick : rx_tick;
        tx_run      = tx_en & ~rexmit;
        rx_run      = sel.local_lb ? tx_en : rx_en;
    end

    assign rx_push = rx_out_s.push;
    assign rx_perr = rx_out_s.perr;
    assign rx_ferr = rx_out_s.ferr;
    assign rx_brk  = rx_out_s.brk;

    // R4
    local_txd_high_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == MODE_LOCAL) |-> (txd == 1'b1 && rx_serial == tx_serial));

    // R2
    echo_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == MODE_ECHO || mode_sel == MODE_REMOTE) |-> (tx_tick_sel == rx_tick));

    // R1
    normal_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == MODE_NORMAL) |-> (txd == tx_serial && rx_serial == rxd));

    // R8
    run_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == MODE_ECHO || mode_sel == MODE_REMOTE) |-> !tx_run);
endmodule

// File: tb/crm_mode_router_bench.sv
module crm_mode_router_bench;
    logic clk = 1'b0;
    logic rst;
    logic [1:0] mode_sel;
    logic tx_en, rx_en, tx_tick, rx_tick, tx_serial, rxd;
    logic txd, rx_serial, tx_tick_sel, rx_tick_sel, tx_run, rx_run;
    logic cpu_tx_load, tx_load, tx_ready_in, tx_empty_in, tx_ready, tx_empty;
    logic rx_push_in, rx_perr_in, rx_ferr_in, rx_brk_in;
    logic rx_push, rx_perr, rx_ferr, rx_brk, rx_chk_parity, rx_chk_frame;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    crm_mode_router u_crm_mode_router (.*);

    // stimulus: mode,txs,rxd,txt,rxt,txen,rxen,txrdy,txemp,load,push,perr,ferr,brk,spare
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        16'b00_1_0_1_0_1_1_1_0_1_1_0_1_0_0,
        16'b00_0_1_0_1_0_1_0_1_0_0_1_0_1_0,
        16'b01_1_1_1_0_1_1_1_1_1_1_1_1_1_0,
        16'b01_0_1_0_1_1_0_1_0_1_0_1_0_1_0,
        16'b10_0_1_1_0_0_1_1_1_1_1_0_1_0_0,
        16'b10_1_0_0_1_1_0_0_1_0_0_1_0_1_0,
        16'b10_0_0_1_1_1_1_1_0_1_1_1_1_1_0,
        16'b11_1_1_1_0_1_1_1_1_1_1_1_1_1_0,
        16'b11_0_0_0_1_0_1_0_0_0_1_0_1_1_0,
        16'b11_1_1_1_1_1_0_1_1_0_1_1_0_0_0,
        16'b00_1_1_1_1_1_1_1_1_1_1_1_1_1_0,
        16'b01_0_1_1_1_0_1_0_1_1_0_0_1_0_0
    };

    function automatic logic [13:0] model(input logic [15:0] v);
        logic [1:0] m;
        logic txs, rd, txt, rxt, te, re, rdy, emp, ld, ps, pe, fe, bk;
        {m, txs, rd, txt, rxt, te, re, rdy, emp, ld, ps, pe, fe, bk} = v[15:1];
        case (m)
            2'd0: return {rd, txt, rxt, rdy, emp, ld, ps, pe, fe, bk, 2'b11, te, re};
            2'd1: return {rd, rxt, rxt, 3'b000, ps, pe, fe, bk, 2'b11, 1'b0, re};
            2'd2: return {txs, txt, txt, rdy, emp, ld, ps, pe, fe, bk, 2'b11, te, te};
            default: return {rd, rxt, rxt, rdy, emp, ld, 6'b000000, 1'b0, re};
        endcase
    endfunction

    function automatic logic [13:0] observed();
        return {rx_serial, tx_tick_sel, rx_tick_sel, tx_ready, tx_empty, tx_load,
                rx_push, rx_perr, rx_ferr, rx_brk, rx_chk_parity, rx_chk_frame,
                tx_run, rx_run};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] v);
        {mode_sel, tx_serial, rxd, tx_tick, rx_tick, tx_en, rx_en, tx_ready_in,
         tx_empty_in, cpu_tx_load, rx_push_in, rx_perr_in, rx_ferr_in, rx_brk_in} = v[15:1];
    endtask

    task automatic tick_rx(input logic bitval);
        @(negedge clk);
        rxd = bitval; rx_tick = 1'b1;
        @(negedge clk);
        rx_tick = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        apply(16'b01_1_0_0_1_0_1_0_0_0_0_0_0_0_0);
        repeat (3) @(posedge clk);
        #1;
        // R9 reset leaves echo register idle, seen on txd in echo mode
        check("R9", {15'd0, txd}, 16'd1);
        @(negedge clk);
        rst = 1'b0;
        rx_tick = 1'b0;

        // R1 R3 R4 R5 R8 table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            #1;
            case (VEC[i][15:14])
                2'd0: check("R1", {2'b0, observed()}, {2'b0, model(VEC[i])});
                2'd1: check("R3", {2'b0, observed()}, {2'b0, model(VEC[i])});
                2'd2: check("R4", {2'b0, observed()}, {2'b0, model(VEC[i])});
                default: check("R5", {2'b0, observed()}, {2'b0, model(VEC[i])});
            endcase
            if (VEC[i][15:14] == 2'd0) check("R1", {15'd0, txd}, {15'd0, VEC[i][13]});
            if (VEC[i][15:14] == 2'd2) check("R4", {15'd0, txd}, 16'd1);
        end

        // R2 echo latency: txd follows rxd one clock after the tick
        @(negedge clk);
        apply(16'b01_1_1_0_0_0_1_0_0_0_0_0_0_0_0);
        tick_rx(1'b1);
        @(negedge clk);
        rxd = 1'b0; rx_tick = 1'b1;
        #1 check("R2", {15'd0, txd}, 16'd1);
        @(posedge clk); #1;
        check("R2", {15'd0, txd}, 16'd0);
        @(negedge clk);
        rx_tick = 1'b0; rxd = 1'b1;
        @(posedge clk); #1;
        check("R2", {15'd0, txd}, 16'd0);

        // R6 break held low in remote loopback
        @(negedge clk);
        mode_sel = 2'd3;
        for (int k = 0; k < 20; k++) tick_rx(1'b0);
        #1 check("R6", {15'd0, txd}, 16'd0);
        tick_rx(1'b1);
        #1 check("R6", {15'd0, txd}, 16'd1);

        // R7 mode switch in mid-character takes effect the same cycle
        tick_rx(1'b0);
        @(negedge clk);
        mode_sel = 2'd0; tx_serial = 1'b1;
        #1 check("R7", {15'd0, txd}, 16'd1);
        @(negedge clk);
        mode_sel = 2'd1;
        #1 check("R7", {15'd0, txd}, 16'd0);
        @(negedge clk);
        mode_sel = 2'd2;
        #1 check("R7", {15'd0, txd}, 16'd1);

        // R4 rxd ignored in local loopback
        @(negedge clk);
        tx_serial = 1'b0;
        tick_rx(1'b1);
        #1 check("R4", {14'd0, txd, rx_serial}, 16'b10);

        // R8 receiver disable returns echo register to idle
        @(negedge clk);
        mode_sel = 2'd1;
        tick_rx(1'b0);
        #1 check("R8", {15'd0, txd}, 16'd0);
        @(negedge clk);
        rx_en = 1'b0;
        @(posedge clk); #1;
        check("R8", {15'd0, txd}, 16'd1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule